// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks an attached DRAM through its mode-register bring-up after reset. Once a start pulse arrives, it reads a strap that selects a first-generation or second-generation DDR device. It then steps through a fixed list of commands. Each command leaves the block as a single-clock pulse on one bit of a command strobe vector. When a step programs the mode register or the extended-mode register, the new value appears on the matching output in the same cycle as the pulse. That value then holds until a later step loads that register again.

Each step is followed by a wait timed by a down-counter, and the wait length is a parameter given in clock cycles. The second-generation list opens with two short-gap extended-register pulses. Both lists reset the DLL with one mode write and later issue a normal mode write. The second-generation list ends with an enter/exit pair that sets and then clears the off-chip driver calibration default. After the wait that follows the final command, the block enables periodic refresh, drives the refresh interval and raises done. Done holds until the next reset.

The downstream command path turns the strobes into DRAM bus cycles. Pin timing, the PHY and data movement belong to other blocks.

Top module: `dram_init_seq`

## Requirements
- R1: Every output is zero after reset: strobe vector, mode value, extended-mode value, refresh enable, refresh interval and done.
- R2: Strobe bit 0 is mode-register set, bit 1 is extended-mode set, bit 2 is auto refresh, bit 3 is precharge-all, bit 4 is extended-mode-2 set and bit 5 is extended-mode-3 set. At most one bit is high in any cycle, and each command is high for exactly one clock.
- R3: With the strap high (second generation), the strobes are, in order: 0x10, 0x20, 0x08, 0x10, 0x20, 0x02 with extended mode 0x402, 0x01 with mode 0x143, 0x08, 0x04, 0x04, 0x01 with mode 0x043, 0x02 with extended mode 0x782, and 0x02 with extended mode 0x402.
- R4: With the strap low (first generation), the strobes are, in order: 0x08, 0x02 with extended mode 0x000, 0x01 with mode 0x133, 0x08, 0x04, 0x04, and 0x01 with mode 0x033.
- R5: A loaded mode or extended-mode value is valid in the strobe cycle of its command. It stays unchanged until another step loads the same register.
- R6: Consecutive strobes are exactly LONG_WAIT clocks apart. The exceptions are the gaps after the first and second second-generation strobes, which are exactly SHORT_WAIT clocks.
- R7: The first strobe is high in the cycle right after the clock edge that samples start high in idle. The strap is read at that edge only. Without a start, no strobe is issued.
- R8: Exactly LONG_WAIT clocks after the last strobe, done and refresh enable rise together. The refresh interval then reads REF_INTERVAL (default 312), and before that point it reads zero.
- R9: A start that arrives while the sequence runs, or after done, has no effect on the strobes or on the register values.
- R10: Done stays high until reset. A reset in mid-sequence returns the block to idle with every output cleared, and a later start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the sequence when the block is idle |
| ddr2_sel | input | 1 | Strap: 1 selects the second-generation list, 0 the first |
| cmd_strobe | output | 6 | One-hot command pulse, encoding as in R2 |
| mode_val | output | 13 | Current mode-register value |
| ext_mode_val | output | 13 | Current extended-mode-register value |
| refresh_en | output | 1 | Periodic refresh enable |
| refresh_interval | output | REF_W (10) | Refresh interval field |
| done | output | 1 | Sequence finished |

## Verification
Two functions can fall in the same cycle: a start arriving on the very edge where a wait expires and the next step is issued, and a start arriving on the edge where the final wait expires and done is raised. The bench holds start high for the whole sequence and flips the strap partway through, so the start input is present at every issue edge and at the finishing edge. A pass requires the logged strobe list, the register values and the strobe spacing to match a single second-generation run exactly, with nothing logged after done.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  localparam int CMD_W  = 6;
  localparam int MODE_W = 13;
  localparam int IDX_W  = 4;

  // one-hot command codes (bit position is the downstream decode)
  localparam logic [CMD_W-1:0] CMD_MRS  = 6'b000001;
  localparam logic [CMD_W-1:0] CMD_EMRS = 6'b000010;
  localparam logic [CMD_W-1:0] CMD_AREF = 6'b000100;
  localparam logic [CMD_W-1:0] CMD_PREA = 6'b001000;
  localparam logic [CMD_W-1:0] CMD_EMR2 = 6'b010000;
  localparam logic [CMD_W-1:0] CMD_EMR3 = 6'b100000;

  // register images
  localparam logic [MODE_W-1:0] G1_EMR_RUN   = 13'h000;
  localparam logic [MODE_W-1:0] G1_MR_DLLRST = 13'h133;
  localparam logic [MODE_W-1:0] G1_MR_RUN    = 13'h033;
  localparam logic [MODE_W-1:0] G2_EMR_RUN   = 13'h402;
  localparam logic [MODE_W-1:0] G2_EMR_OCD   = 13'h782;
  localparam logic [MODE_W-1:0] G2_MR_DLLRST = 13'h143;
  localparam logic [MODE_W-1:0] G2_MR_RUN    = 13'h043;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_MR   = 2'd1,
    LD_EMR  = 2'd2
  } load_sel_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    load_sel_e         ld;
    logic [MODE_W-1:0] value;
    logic              short_gap;
    logic              last;
  } step_t;

  function automatic step_t mk_step(input logic [CMD_W-1:0] c, input load_sel_e l,
                                    input logic [MODE_W-1:0] v, input logic sg,
                                    input logic fin);
    step_t s;
    s.cmd       = c;
    s.ld        = l;
    s.value     = v;
    s.short_gap = sg;
    s.last      = fin;
    return s;
  endfunction

endpackage

// File: rtl/dram_init_steps.sv
module dram_init_steps
  import dram_init_pkg::*;
(
  input  logic             gen2,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  always_comb begin
    step = mk_step(CMD_PREA, LD_NONE, '0, 1'b0, 1'b1);
    if (gen2) begin
      case (idx)
        4'd0:  step = mk_step(CMD_EMR2, LD_NONE, '0,           1'b1, 1'b0);
        4'd1:  step = mk_step(CMD_EMR3, LD_NONE, '0,           1'b1, 1'b0);
        4'd2:  step = mk_step(CMD_PREA, LD_NONE, '0,           1'b0, 1'b0);
        4'd3:  step = mk_step(CMD_EMR2, LD_NONE, '0,           1'b0, 1'b0);
        4'd4:  step = mk_step(CMD_EMR3, LD_NONE, '0,           1'b0, 1'b0);
        4'd5:  step = mk_step(CMD_EMRS, LD_EMR,  G2_EMR_RUN,   1'b0, 1'b0);
        4'd6:  step = mk_step(CMD_MRS,  LD_MR,   G2_MR_DLLRST, 1'b0, 1'b0);
        4'd7:  step = mk_step(CMD_PREA, LD_NONE, '0,           1'b0, 1'b0);
        4'd8:  step = mk_step(CMD_AREF, LD_NONE, '0,           1'b0, 1'b0);
        4'd9:  step = mk_step(CMD_AREF, LD_NONE, '0,           1'b0, 1'b0);
        4'd10: step = mk_step(CMD_MRS,  LD_MR,   G2_MR_RUN,    1'b0, 1'b0);
        4'd11: step = mk_step(CMD_EMRS, LD_EMR,  G2_EMR_OCD,   1'b0, 1'b0);
        4'd12: step = mk_step(CMD_EMRS, LD_EMR,  G2_EMR_RUN,   1'b0, 1'b1);
        default: ;
      endcase
    end else begin
      case (idx)
        4'd0: step = mk_step(CMD_PREA, LD_NONE, '0,           1'b0, 1'b0);
        4'd1: step = mk_step(CMD_EMRS, LD_EMR,  G1_EMR_RUN,   1'b0, 1'b0);
        4'd2: step = mk_step(CMD_MRS,  LD_MR,   G1_MR_DLLRST, 1'b0, 1'b0);
        4'd3: step = mk_step(CMD_PREA, LD_NONE, '0,           1'b0, 1'b0);
        4'd4: step = mk_step(CMD_AREF, LD_NONE, '0,           1'b0, 1'b0);
        4'd5: step = mk_step(CMD_AREF, LD_NONE, '0,           1'b0, 1'b0);
        4'd6: step = mk_step(CMD_MRS,  LD_MR,   G1_MR_RUN,    1'b0, 1'b1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dram_init_timer.sv
module dram_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign expired = (count == '0);

  // gap length depends on a strict one-per-clock countdown
  assert_timer_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/dram_init_refresh.sv
module dram_init_refresh #(
  parameter int REF_W        = 10,
  parameter int REF_INTERVAL = 312
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  output logic             refresh_en,
  output logic [REF_W-1:0] refresh_interval
);

  always_ff @(posedge clk) begin
    if (rst) begin
      refresh_en       <= 1'b0;
      refresh_interval <= '0;
    end else if (arm) begin
      refresh_en       <= 1'b1;
      refresh_interval <= REF_W'(REF_INTERVAL);
    end
  end

  assert_refresh_hold_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_en |=> (refresh_en && refresh_interval == REF_W'(REF_INTERVAL)));

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int LONG_WAIT    = 12500,
  parameter int SHORT_WAIT   = 1250,
  parameter int REF_W        = 10,
  parameter int REF_INTERVAL = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ddr2_sel,
  output logic [CMD_W-1:0]  cmd_strobe,
  output logic [MODE_W-1:0] mode_val,
  output logic [MODE_W-1:0] ext_mode_val,
  output logic              refresh_en,
  output logic [REF_W-1:0]  refresh_interval,
  output logic              done
);

  localparam int WAIT_MAX = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CNT_W    = $clog2(WAIT_MAX) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} seq_state_e;

  seq_state_e       state;
  logic [IDX_W-1:0] idx_q;
  logic             gen2_q;
  logic             last_q;

  logic             in_idle;
  logic             lookup_gen2;
  logic [IDX_W-1:0] lookup_idx;
  step_t            step;
  logic             timer_expired;
  logic             issue;
  logic             finish;
  logic [CNT_W-1:0] gap_val;

  assign in_idle     = (state == ST_IDLE);
  assign lookup_gen2 = in_idle ? ddr2_sel : gen2_q;
  assign lookup_idx  = in_idle ? '0 : idx_q + 1'b1;

  dram_init_steps u_steps (
    .gen2 (lookup_gen2),
    .idx  (lookup_idx),
    .step (step)
  );

  assign issue   = (in_idle && start) || (state == ST_WAIT && timer_expired && !last_q);
  assign finish  = (state == ST_WAIT) && timer_expired && last_q;
  assign gap_val = step.short_gap ? CNT_W'(SHORT_WAIT - 1) : CNT_W'(LONG_WAIT - 1);

  dram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (issue),
    .load_val (gap_val),
    .expired  (timer_expired)
  );

  dram_init_refresh #(.REF_W(REF_W), .REF_INTERVAL(REF_INTERVAL)) u_refresh (
    .clk              (clk),
    .rst              (rst),
    .arm              (finish),
    .refresh_en       (refresh_en),
    .refresh_interval (refresh_interval)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx_q        <= '0;
      gen2_q       <= 1'b0;
      last_q       <= 1'b0;
      cmd_strobe   <= '0;
      mode_val     <= '0;
      ext_mode_val <= '0;
      done         <= 1'b0;
    end else begin
      cmd_strobe <= '0;
      if (issue) begin
        state      <= ST_WAIT;
        idx_q      <= lookup_idx;
        last_q     <= step.last;
        cmd_strobe <= step.cmd;
        if (in_idle) gen2_q <= ddr2_sel;
        if (step.ld == LD_MR)  mode_val     <= step.value;
        if (step.ld == LD_EMR) ext_mode_val <= step.value;
      end else if (finish) begin
        state <= ST_DONE;
        done  <= 1'b1;
      end
    end
  end

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_strobe));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe != '0) |=> (cmd_strobe == '0));

  assert_no_start_effect_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !timer_expired) |=> (cmd_strobe == '0 && $stable(mode_val)
                                             && $stable(ext_mode_val)));

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd_strobe == '0));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_refresh_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (refresh_en && refresh_interval == REF_W'(REF_INTERVAL)));

endmodule

// File: tb/dram_init_seq_test.sv
`timescale 1ns/1ps
module dram_init_seq_test;

  localparam int LW  = 20;
  localparam int SW  = 6;
  localparam int RI  = 312;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ddr2_sel = 1'b0;
  logic [5:0]  cmd_strobe;
  logic [12:0] mode_val;
  logic [12:0] ext_mode_val;
  logic        refresh_en;
  logic [9:0]  refresh_interval;
  logic        done;

  dram_init_seq #(.LONG_WAIT(LW), .SHORT_WAIT(SW), .REF_W(10), .REF_INTERVAL(RI)) uut (
    .clk(clk), .rst(rst), .start(start), .ddr2_sel(ddr2_sel),
    .cmd_strobe(cmd_strobe), .mode_val(mode_val), .ext_mode_val(ext_mode_val),
    .refresh_en(refresh_en), .refresh_interval(refresh_interval), .done(done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // monitor: sole writer of the log
  int cyc = 0;
  int n_ev = 0;
  int ev_cyc [256];
  int ev_cmd [256];
  int ev_mr  [256];
  int ev_emr [256];
  int done_cyc = -1;
  logic done_q = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_strobe != 6'd0 && n_ev < 256) begin
      ev_cyc[n_ev] = cyc;
      ev_cmd[n_ev] = int'(cmd_strobe);
      ev_mr[n_ev]  = int'(mode_val);
      ev_emr[n_ev] = int'(ext_mode_val);
      n_ev = n_ev + 1;
    end
    if (done && !done_q) done_cyc = cyc;
    done_q = done;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int e_cmd(input bit d2, input int i);
    if (d2) begin
      case (i)
        0: return 'h10; 1: return 'h20; 2: return 'h08; 3: return 'h10;
        4: return 'h20; 5: return 'h02; 6: return 'h01; 7: return 'h08;
        8: return 'h04; 9: return 'h04; 10: return 'h01; 11: return 'h02;
        default: return 'h02;
      endcase
    end
    case (i)
      0: return 'h08; 1: return 'h02; 2: return 'h01; 3: return 'h08;
      4: return 'h04; 5: return 'h04; default: return 'h01;
    endcase
  endfunction

  // value loaded by step i: -1 for none
  function automatic int e_val(input bit d2, input int i);
    if (d2) begin
      case (i)
        5: return 'h402; 6: return 'h143; 10: return 'h043;
        11: return 'h782; 12: return 'h402; default: return -1;
      endcase
    end
    case (i)
      1: return 'h000; 2: return 'h133; 6: return 'h033; default: return -1;
    endcase
  endfunction

  function automatic int e_gap(input bit d2, input int i);
    return (d2 && i < 2) ? SW : LW;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start(input bit d2, output int scyc);
    @(negedge clk);
    ddr2_sel = d2;
    start = 1'b1;
    @(negedge clk);
    scyc = cyc;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
  endtask

  task automatic check_run(input bit d2, input int base, input int scyc);
    int n = d2 ? 13 : 7;
    int mr = 0;
    int emr = 0;
    int t = scyc;
    string rq = d2 ? "R3" : "R4";
    chk(n_ev - base == n, rq, "strobe count", n_ev - base, n);
    for (int i = 0; i < n; i++) begin
      if (base + i < n_ev) begin
        chk(ev_cmd[base+i] == e_cmd(d2, i), rq, $sformatf("step %0d strobe", i), ev_cmd[base+i], e_cmd(d2, i));
        if (e_cmd(d2, i) == 'h01 && e_val(d2, i) >= 0) mr = e_val(d2, i);
        if (e_cmd(d2, i) == 'h02 && e_val(d2, i) >= 0) emr = e_val(d2, i);
        chk(ev_mr[base+i] == mr, "R5", $sformatf("step %0d mode", i), ev_mr[base+i], mr);
        chk(ev_emr[base+i] == emr, "R5", $sformatf("step %0d ext mode", i), ev_emr[base+i], emr);
        chk(ev_cyc[base+i] == t, (i == 0) ? "R7" : "R6", $sformatf("step %0d cycle", i), ev_cyc[base+i], t);
      end
      t = t + e_gap(d2, i);
    end
    chk(done_cyc == t, "R8", "done cycle", done_cyc, t);
    chk(refresh_en == 1'b1, "R8", "refresh enable", int'(refresh_en), 1);
    chk(int'(refresh_interval) == RI, "R8", "refresh interval", int'(refresh_interval), RI);
  endtask

  task automatic check_idle_outputs(input string req);
    chk(cmd_strobe == 6'd0, req, "strobe", int'(cmd_strobe), 0);
    chk(mode_val == 13'd0, req, "mode", int'(mode_val), 0);
    chk(ext_mode_val == 13'd0, req, "ext mode", int'(ext_mode_val), 0);
    chk(refresh_en == 1'b0, req, "refresh enable", int'(refresh_en), 0);
    chk(refresh_interval == 10'd0, req, "refresh interval", int'(refresh_interval), 0);
    chk(done == 1'b0, req, "done", int'(done), 0);
  endtask

  task automatic test_reset_state();
    int base;
    do_reset();
    check_idle_outputs("R1");
    base = n_ev;
    repeat (30) @(negedge clk);
    chk(n_ev == base, "R7", "strobes without start", n_ev - base, 0);
  endtask

  task automatic test_gen2_run();
    int base, scyc;
    do_reset();
    base = n_ev;
    pulse_start(1'b1, scyc);
    wait_done();
    @(negedge clk);
    check_run(1'b1, base, scyc);
  endtask

  task automatic test_gen1_run();
    int base, scyc;
    do_reset();
    base = n_ev;
    pulse_start(1'b0, scyc);
    wait_done();
    @(negedge clk);
    check_run(1'b0, base, scyc);
  endtask

  // start held across every issue edge and the finishing edge; strap flips midway
  task automatic test_start_held();
    int base, scyc, after;
    do_reset();
    base = n_ev;
    @(negedge clk);
    ddr2_sel = 1'b1;
    start = 1'b1;
    @(negedge clk);
    scyc = cyc;
    repeat (50) @(negedge clk);
    ddr2_sel = 1'b0;
    wait_done();
    @(negedge clk);
    check_run(1'b1, base, scyc);
    after = n_ev;
    repeat (3 * LW) @(negedge clk);
    chk(n_ev == after, "R9", "strobes after done", n_ev - after, 0);
    chk(mode_val == 13'h043, "R9", "mode after done", int'(mode_val), 'h043);
    chk(ext_mode_val == 13'h402, "R9", "ext mode after done", int'(ext_mode_val), 'h402);
    chk(done == 1'b1, "R10", "done holds", int'(done), 1);
    start = 1'b0;
  endtask

  task automatic test_reset_mid();
    int base, scyc;
    do_reset();
    pulse_start(1'b0, scyc);
    repeat (2 * LW + 5) @(negedge clk);
    chk(refresh_en == 1'b0, "R8", "refresh before done", int'(refresh_en), 0);
    chk(refresh_interval == 10'd0, "R8", "interval before done", int'(refresh_interval), 0);
    rst = 1'b1;
    @(negedge clk);
    check_idle_outputs("R10");
    @(negedge clk);
    rst = 1'b0;
    repeat (2 * LW) @(negedge clk);
    base = n_ev;
    chk(done == 1'b0, "R10", "idle after mid reset", int'(done), 0);
    pulse_start(1'b0, scyc);
    wait_done();
    @(negedge clk);
    check_run(1'b0, base, scyc);
  endtask

  initial begin
    test_reset_state();
    test_gen2_run();
    test_gen1_run();
    test_start_held();
    test_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

endmodule